// File: doc/BRIEF.md
# Privilege-Filtered Cycle Counter

This block is a 64-bit cycle counter that advances by one on every clock, except when a filter control register says the current processor context must not be counted. The context arrives on input pins and is evaluated in the same cycle. It consists of the privilege level (0 to 3), the security state (Secure, Non-secure or Realm), a streaming-vector-mode flag and a transactional-state flag. A global enable gates all counting.

Software reaches the filter register and the counter through a simple single-cycle register port. Each of them is seen as two 32-bit words at fixed offsets. Reads are combinational. A write lands on the next clock edge.

The filter uses absolute bits at the security-agnostic levels. Its secondary bits work relative to a primary bit: whether a secondary bit equals or differs from its primary bit decides suppression, not its own value. Reserved filter bits always read as zero.

Top module: `cyc_filt_top`

## Requirements
- R1: After synchronous reset, the counter is 0 and both filter words read 0.
- R2: While `cnt_enable` is high and no filter term suppresses, the counter rises by exactly 1 per clock. While `cnt_enable` is low, it holds its value.
- R3: Filter-low bit 31 (P) and bit 30 (U) control levels 1 and 0. In the Secure state, level 1 is suppressed when P=1, and level 0 is suppressed when U=1. In Non-secure, level 1 is suppressed when bit 29 differs from P, and level 0 when bit 28 differs from U. In Realm, level 1 is suppressed when bit 22 differs from P, and level 0 when bit 21 differs from U.
- R4: At level 2, with bit 27 as H: Non-secure is suppressed when H=0. Secure is suppressed when bit 24 equals H. Realm is suppressed when bit 20 equals H.
- R5: At level 3, counting is suppressed when filter-low bit 26 differs from P, whatever the security state.
- R6: When filter-low bit 23 is 1 and `ctx_txn` is 0 (non-transactional), counting is suppressed.
- R7: Filter-high bits [25:24] select vector-mode filtering. 01 suppresses when `ctx_streaming`=1, and 10 suppresses when `ctx_streaming`=0. 00 and the reserved 11 apply no vector filter; a written 11 reads back as 11.
- R8: Only filter-low bits 31:26 and 24:20 and filter-high bits 25:24 are writable. All other filter bits read 0 and ignore writes. Unmapped offsets read 0, and writes to them have no effect.
- R9: From all-ones, the counter wraps to zero on the next counted cycle without stalling.
- R10: Offsets are 0x47C (filter low), 0xA7C (filter high), 0x0F8 (counter low) and 0x0FC (counter high). A write to a counter half replaces that half on the next clock and keeps the other half, and no increment happens in that cycle.
- R11: `count_active` is high in exactly the cycles where the counter will increment (enable high, no suppression, no counter write). The security encoding is 00 Secure, 01 Non-secure, 10 Realm, and 11 is treated as Non-secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_enable | input | 1 | Global counting enable |
| ctx_level | input | 2 | Current privilege level 0..3 |
| ctx_sec | input | 2 | Security state: 00 Secure, 01 Non-secure, 10 Realm |
| ctx_streaming | input | 1 | 1 when in streaming vector mode |
| ctx_txn | input | 1 | 1 when in transactional state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| count_out | output | 64 | Current counter value |
| count_active | output | 1 | Counter increments at the coming edge |

## Verification
A wrong stored filter bit shows up in two places in the same cycle. It appears in `reg_rdata` when that word is addressed, and in `count_active` for any context that decodes the bit. On the following edge it also shows as a count that drifts from the reference.

A wrong counter register shows on `count_out` one clock after the faulty edge, and the error persists because the counter holds state. The bench therefore compares `count_active` and the read port mid-cycle, and compares `count_out` after every edge. It does this under random contexts and random register writes, so a single bad decode term is caught on the first cycle that reaches it.

// File: rtl/cyc_filt_pkg.sv
package cyc_filt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_FLT_LO = 12'h47C;
    localparam logic [ADDR_W-1:0] OFF_FLT_HI = 12'hA7C;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 12'h0F8;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 12'h0FC;

    localparam logic [DATA_W-1:0] FLT_LO_MASK = 32'hFDF0_0000;
    localparam logic [DATA_W-1:0] FLT_HI_MASK = 32'h0300_0000;

    typedef enum logic [1:0] {
        SEC_SECURE = 2'b00,
        SEC_NONSEC = 2'b01,
        SEC_REALM  = 2'b10,
        SEC_RSVD   = 2'b11
    } sec_e;

    typedef enum logic [1:0] {
        VEC_NONE      = 2'b00,
        VEC_NO_STREAM = 2'b01,
        VEC_NO_NORMAL = 2'b10,
        VEC_RSVD      = 2'b11
    } vec_e;

    typedef struct packed {
        logic p;
        logic u;
        logic ns_k;
        logic ns_u;
        logic h;
        logic top;
        logic sec_h;
        logic ntx;
        logic rl_k;
        logic rl_u;
        logic rl_h;
        vec_e vec;
    } filt_t;

    typedef struct packed {
        logic [1:0] level;
        sec_e       sec;
        logic       streaming;
        logic       txn;
    } ctx_t;

    function automatic filt_t unpack_filt(logic [DATA_W-1:0] lo, logic [DATA_W-1:0] hi);
        filt_t f;
        f.p     = lo[31];
        f.u     = lo[30];
        f.ns_k  = lo[29];
        f.ns_u  = lo[28];
        f.h     = lo[27];
        f.top   = lo[26];
        f.sec_h = lo[24];
        f.ntx   = lo[23];
        f.rl_k  = lo[22];
        f.rl_u  = lo[21];
        f.rl_h  = lo[20];
        f.vec   = vec_e'(hi[25:24]);
        return f;
    endfunction

    // Relative (secondary) bits: mismatch or match against the primary bit decides.
    function automatic logic level_block(filt_t f, ctx_t c);
        logic blk;
        blk = 1'b0;
        unique case (c.level)
            2'd0: begin
                unique case (c.sec)
                    SEC_SECURE: blk = f.u;
                    SEC_REALM:  blk = f.u ^ f.rl_u;
                    default:    blk = f.u ^ f.ns_u;
                endcase
            end
            2'd1: begin
                unique case (c.sec)
                    SEC_SECURE: blk = f.p;
                    SEC_REALM:  blk = f.p ^ f.rl_k;
                    default:    blk = f.p ^ f.ns_k;
                endcase
            end
            2'd2: begin
                unique case (c.sec)
                    SEC_SECURE: blk = (f.sec_h == f.h);
                    SEC_REALM:  blk = (f.rl_h == f.h);
                    default:    blk = ~f.h;
                endcase
            end
            default: blk = f.top ^ f.p;
        endcase
        return blk;
    endfunction

    function automatic logic vec_block(filt_t f, ctx_t c);
        unique case (f.vec)
            VEC_NO_STREAM: return c.streaming;
            VEC_NO_NORMAL: return ~c.streaming;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cyc_filt_decode.sv
module cyc_filt_decode
    import cyc_filt_pkg::*;
(
    input  filt_t filt,
    input  ctx_t  ctx,
    input  logic  enable,
    output logic  count_ok
);
    localparam int N_TERMS = 3;

    logic [N_TERMS-1:0] blk;

    always_comb begin
        blk[0] = level_block(filt, ctx);
        blk[1] = filt.ntx & ~ctx.txn;
        blk[2] = vec_block(filt, ctx);
    end

    assign count_ok = enable & ~(|blk);

    // The transactional filter is an absolute suppression, independent of level.
    always_comb begin
        if (filt.ntx && !ctx.txn)
            a_r6_ntx_blocks: assert (!count_ok);
    end

endmodule

// File: rtl/cyc_filt_regs.sv
module cyc_filt_regs
    import cyc_filt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output filt_t             filt,
    output logic              cnt_wr_lo,
    output logic              cnt_wr_hi,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = CNT_W / 2;

    logic [DATA_W-1:0] flt_lo_q;
    logic [DATA_W-1:0] flt_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_lo_q <= '0;
            flt_hi_q <= '0;
        end else if (wr) begin
            if (addr == OFF_FLT_LO) flt_lo_q <= wdata & FLT_LO_MASK;
            if (addr == OFF_FLT_HI) flt_hi_q <= wdata & FLT_HI_MASK;
        end
    end

    assign filt      = unpack_filt(flt_lo_q, flt_hi_q);
    assign cnt_wr_lo = wr && (addr == OFF_CNT_LO);
    assign cnt_wr_hi = wr && (addr == OFF_CNT_HI);

    always_comb begin
        unique case (addr)
            OFF_FLT_LO: rdata = flt_lo_q;
            OFF_FLT_HI: rdata = flt_hi_q;
            OFF_CNT_LO: rdata = count[HALF-1:0];
            OFF_CNT_HI: rdata = count[CNT_W-1:HALF];
            default:    rdata = '0;
        endcase
    end

    a_r8_lo_reserved: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_FLT_LO) |-> ((rdata & ~FLT_LO_MASK) == '0));
    a_r8_hi_reserved: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_FLT_HI) |-> ((rdata & ~FLT_HI_MASK) == '0));

endmodule

// File: rtl/cyc_filt_counter.sv
module cyc_filt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0] count
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_lo) cnt_q <= {cnt_q[CNT_W-1:HALF], wdata};
        else if (wr_hi) cnt_q <= {wdata, cnt_q[HALF-1:0]};
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (count == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_lo && !wr_hi) |=> $stable(count));
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_lo && !wr_hi && (&count)) |=> (count == '0));
    a_r10_write_lo: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count[HALF-1:0] == $past(wdata)) &&
                  (count[CNT_W-1:HALF] == $past(count[CNT_W-1:HALF])));

endmodule

// File: rtl/cyc_filt_top.sv
module cyc_filt_top
    import cyc_filt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_enable,
    input  logic [1:0]        ctx_level,
    input  logic [1:0]        ctx_sec,
    input  logic              ctx_streaming,
    input  logic              ctx_txn,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_active
);
    filt_t filt;
    ctx_t  ctx;
    logic  count_ok;
    logic  wr_lo;
    logic  wr_hi;

    assign ctx.level     = ctx_level;
    assign ctx.sec       = sec_e'(ctx_sec);
    assign ctx.streaming = ctx_streaming;
    assign ctx.txn       = ctx_txn;

    cyc_filt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .count     (count_out),
        .filt      (filt),
        .cnt_wr_lo (wr_lo),
        .cnt_wr_hi (wr_hi),
        .rdata     (reg_rdata)
    );

    cyc_filt_decode u_decode (
        .filt     (filt),
        .ctx      (ctx),
        .enable   (cnt_enable),
        .count_ok (count_ok)
    );

    assign count_active = count_ok & ~wr_lo & ~wr_hi;

    cyc_filt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .inc   (count_active),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .count (count_out)
    );

    a_r11_needs_enable: assert property (@(posedge clk) disable iff (rst)
        count_active |-> cnt_enable);

endmodule

// File: tb/cyc_filt_top_test.sv
module cyc_filt_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_FLO = 12'h47C;
    localparam logic [11:0] A_FHI = 12'hA7C;
    localparam logic [11:0] A_CLO = 12'h0F8;
    localparam logic [11:0] A_CHI = 12'h0FC;
    localparam logic [31:0] M_LO  = 32'hFDF0_0000;
    localparam logic [31:0] M_HI  = 32'h0300_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_enable = 1'b0;
    logic [1:0]  ctx_level = '0;
    logic [1:0]  ctx_sec = '0;
    logic        ctx_streaming = 1'b0;
    logic        ctx_txn = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] count_out;
    logic        count_active;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_hi = '0;
    logic [63:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_filt_top uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit exp_block(logic [1:0] lvl, logic [1:0] sec, bit strm, bit txn);
        bit p = m_lo[31], u = m_lo[30], h = m_lo[27];
        bit b;
        case (lvl)
            2'd0: b = (sec == 2'b00) ? u : (sec == 2'b10) ? (u != m_lo[21]) : (u != m_lo[28]);
            2'd1: b = (sec == 2'b00) ? p : (sec == 2'b10) ? (p != m_lo[22]) : (p != m_lo[29]);
            2'd2: b = (sec == 2'b00) ? (m_lo[24] == h) : (sec == 2'b10) ? (m_lo[20] == h) : !h;
            default: b = (m_lo[26] != p);
        endcase
        if (m_lo[23] && !txn) b = 1;
        if (m_hi[25:24] == 2'b01 && strm) b = 1;
        if (m_hi[25:24] == 2'b10 && !strm) b = 1;
        return b;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        case (a)
            A_FLO: return m_lo;
            A_FHI: return m_hi;
            A_CLO: return m_cnt[31:0];
            A_CHI: return m_cnt[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic step(input bit en, input logic [1:0] lvl, input logic [1:0] sec,
                        input bit strm, input bit txn, input bit wr,
                        input logic [11:0] addr, input logic [31:0] wd, input string tag);
        bit act;
        cnt_enable = en; ctx_level = lvl; ctx_sec = sec;
        ctx_streaming = strm; ctx_txn = txn;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        #1;
        act = en && !exp_block(lvl, sec, strm, txn) && !(wr && (addr == A_CLO || addr == A_CHI));
        chk(count_active == act, {"R11 ", tag}, 64'(count_active), 64'(act));
        chk(reg_rdata == exp_rd(addr), {"R8 read ", tag}, 64'(reg_rdata), 64'(exp_rd(addr)));
        if (wr && addr == A_CLO)      m_cnt = {m_cnt[63:32], wd};
        else if (wr && addr == A_CHI) m_cnt = {wd, m_cnt[31:0]};
        else if (act)                 m_cnt = m_cnt + 1;
        if (wr && addr == A_FLO) m_lo = wd & M_LO;
        if (wr && addr == A_FHI) m_hi = wd & M_HI;
        @(negedge clk);
        #1;
        chk(count_out == m_cnt, {"count ", tag}, count_out, m_cnt);
        reg_wr = 0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(0, 0, 2'b01, 0, 1, 1, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = 32'h5EED_C0DE;
        logic [11:0] addrs [5];
        addrs[0] = A_FLO; addrs[1] = A_FHI; addrs[2] = A_CLO; addrs[3] = A_CHI; addrs[4] = 12'h100;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(count_out == 0, "R1 counter", count_out, 0);
        step(0, 0, 2'b01, 0, 1, 0, A_FLO, 0, "R1 flt lo");
        step(0, 0, 2'b01, 0, 1, 0, A_FHI, 0, "R1 flt hi");
        // R2: counting and holding
        repeat (5) step(1, 0, 2'b01, 0, 1, 0, A_CLO, 0, "R2 count");
        repeat (3) step(0, 1, 2'b01, 0, 1, 0, A_CLO, 0, "R2 hold");
        // R3: P/U absolute in Secure, relative elsewhere
        wr_reg(A_FLO, 32'h8000_0000, "R3 set P");
        step(1, 1, 2'b00, 0, 1, 0, A_CLO, 0, "R3 secure L1 blocked");
        step(1, 1, 2'b01, 0, 1, 0, A_CLO, 0, "R3 NS L1 mismatch");
        step(1, 1, 2'b10, 0, 1, 0, A_CLO, 0, "R3 realm L1 mismatch");
        wr_reg(A_FLO, 32'hA040_0000, "R3 P=NSK=RLK=1");
        step(1, 1, 2'b01, 0, 1, 0, A_CLO, 0, "R3 NS L1 match");
        step(1, 1, 2'b10, 0, 1, 0, A_CLO, 0, "R3 realm L1 match");
        wr_reg(A_FLO, 32'h1020_0000, "R3 U=0 NSU=RLU=1");
        step(1, 0, 2'b01, 0, 1, 0, A_CLO, 0, "R3 NS L0 mismatch");
        step(1, 0, 2'b10, 0, 1, 0, A_CLO, 0, "R3 realm L0 mismatch");
        step(1, 0, 2'b00, 0, 1, 0, A_CLO, 0, "R3 secure L0 counts");
        // R4: level 2
        wr_reg(A_FLO, 32'h0, "R4 H=0");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R4 NS L2 blocked");
        step(1, 2, 2'b00, 0, 1, 0, A_CLO, 0, "R4 secure L2 equal");
        step(1, 2, 2'b10, 0, 1, 0, A_CLO, 0, "R4 realm L2 equal");
        wr_reg(A_FLO, 32'h0810_0000, "R4 H=1 RLH=1");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R4 NS L2 counts");
        step(1, 2, 2'b00, 0, 1, 0, A_CLO, 0, "R4 secure L2 differs");
        step(1, 2, 2'b10, 0, 1, 0, A_CLO, 0, "R4 realm L2 equal");
        step(1, 2, 2'b11, 0, 1, 0, A_CLO, 0, "R11 sec code 11 as NS");
        // R5: level 3
        wr_reg(A_FLO, 32'h0400_0000, "R5 M=1 P=0");
        step(1, 3, 2'b00, 0, 1, 0, A_CLO, 0, "R5 L3 mismatch");
        wr_reg(A_FLO, 32'h8400_0000, "R5 M=P=1");
        step(1, 3, 2'b10, 0, 1, 0, A_CLO, 0, "R5 L3 match");
        // R6: transactional filter
        wr_reg(A_FLO, 32'h0880_0000, "R6 T=1");
        step(1, 2, 2'b01, 0, 0, 0, A_CLO, 0, "R6 non-txn blocked");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R6 txn counts");
        // R7: vector mode
        wr_reg(A_FLO, 32'h0800_0000, "R7 clear");
        wr_reg(A_FHI, 32'h0100_0000, "R7 VS=01");
        step(1, 2, 2'b01, 1, 1, 0, A_CLO, 0, "R7 streaming blocked");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R7 normal counts");
        wr_reg(A_FHI, 32'h0200_0000, "R7 VS=10");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R7 normal blocked");
        wr_reg(A_FHI, 32'h0300_0000, "R7 VS=11");
        step(1, 2, 2'b01, 1, 1, 0, A_FHI, 0, "R7 reserved no filter");
        step(1, 2, 2'b01, 0, 1, 0, A_FHI, 0, "R7 reserved no filter");
        // R8: reserved bits and unmapped offsets
        wr_reg(A_FLO, 32'hFFFF_FFFF, "R8 all ones lo");
        step(0, 0, 2'b01, 0, 1, 0, A_FLO, 0, "R8 lo mask");
        wr_reg(A_FHI, 32'hFFFF_FFFF, "R8 all ones hi");
        step(0, 0, 2'b01, 0, 1, 0, A_FHI, 0, "R8 hi mask");
        wr_reg(12'h100, 32'hFFFF_FFFF, "R8 unmapped write");
        step(0, 0, 2'b01, 0, 1, 0, 12'h100, 0, "R8 unmapped read");
        wr_reg(A_FLO, 32'h0800_0000, "R8 restore");
        wr_reg(A_FHI, 32'h0, "R8 restore hi");
        // R9: wrap
        wr_reg(A_CHI, 32'hFFFF_FFFF, "R10 write hi");
        wr_reg(A_CLO, 32'hFFFF_FFFE, "R10 write lo");
        repeat (3) step(1, 2, 2'b01, 0, 1, 0, A_CHI, 0, "R9 wrap");
        // R10: write overrides increment
        step(1, 2, 2'b01, 0, 1, 1, A_CLO, 32'h1234_5678, "R10 lo override");
        step(1, 2, 2'b01, 0, 1, 1, A_CHI, 32'h0000_00AB, "R10 hi override");
        step(1, 2, 2'b01, 0, 1, 0, A_CLO, 0, "R10 resume");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit en = ($urandom % 8) != 0;
            bit wr = ($urandom % 6) == 0;
            logic [11:0] a = addrs[$urandom % 5];
            logic [31:0] d = $urandom;
            if (wr && (a == A_CHI || a == A_CLO) && ($urandom % 4) != 0) wr = 0;
            step(en, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                 wr, a, d, "R2 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule